// File: doc/BRIEF.md
# System Clock Controller with Stop and Wake-Up

This block produces the clocking for a small controller core from a single free-running oscillator clock. It does not make derived clocks. It emits two enable pulses. The system enable fires on every oscillator cycle in fast mode, or on every second cycle in half-rate mode. The instruction enable fires on every third system enable. Bit 3 of a 4-bit mode register selects the rate. The three lower bits of that register hold whatever software writes and drive nothing.

A power-off strobe puts the block into a latched stop state, in which both enables are held low. The stop state is left through either of two wake-up paths:
- a falling edge on a pin of a key-input pair whose enable bit is set, or
- an interrupt pin at its selected active level.

Leaving the stop state, and leaving reset, does not restart the clock enables at once. A stabilization counter runs for a set number of oscillator cycles first. Each wake-up also forces the mode register back to half-rate. It sets a warm-start flag, and only reset clears that flag.

Top module: `sysclk_wake_ctrl`

## Requirements
- R1: While reset is asserted, the mode register reads 4'b1000, both enables are low, the halted flag is low and the warm-start flag is low.
- R2: In the running state, a mode write stores all four bits. Bits 2..0 have no effect on clocking and read back exactly as written.
- R3: In the running state, mode bit 3 = 0 gives a system enable on every cycle, and mode bit 3 = 1 gives one on every second cycle.
- R4: The instruction enable is high only together with a system enable, and only on every third system enable. After reset or wake-up, the first instruction enable coincides with the third system enable.
- R5: A power-off strobe seen in the running state sets the halted flag from the next cycle. Both enables then stay low until a wake-up.
- R6: While halted, a high-to-low change on either pin of key pair p (pins 2p and 2p+1) ends the stop state only when bit p of the key-enable register is 1. A change on a disabled pair leaves the block halted.
- R7: While halted, interrupt pin j ends the stop state when it is high with polarity bit j = 1, or low with polarity bit j = 0.
- R8: After reset release or a wake-up, the stabilization counter must finish before clocking resumes. In the half-rate mode that follows either event, the first system enable appears at clock edge WAIT_CYC+1, counted from the wake-up edge or from reset release.
- R9: A wake-up forces the mode register to 4'b1000 and sets the warm-start flag. Only reset clears the warm-start flag.
- R10: Mode writes, key-enable writes and power-off strobes are ignored unless the block is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Mode register write strobe |
| reg_wdata | input | 4 | Mode register write data |
| reg_rdata | output | 4 | Mode register contents |
| ken_wr | input | 1 | Key-enable register write strobe |
| ken_wdata | input | 4 | Key-enable bits, one per key pair |
| pwr_off | input | 1 | Power-off command strobe |
| key_n | input | 8 | Key inputs, four pairs, active low |
| irq_pin | input | 2 | Interrupt wake-up pins |
| irq_pol | input | 2 | Active level per interrupt pin (1 = high) |
| sys_en | output | 1 | System clock enable pulse |
| instr_en | output | 1 | Instruction clock enable pulse |
| halted | output | 1 | Stop state is latched |
| warm_start | output | 1 | Last restart came from a wake-up |

## Verification
The rate logic is driven with fast and half-rate mode values whose lower bits differ. This separates the speed bit from the bits that do nothing, and the pulse counts over a fixed window separate the two rates from the divide-by-three instruction rate.

Wake-up is tried three ways:
- falling edges on a disabled key pair, and then on an enabled pair;
- a low-active interrupt;
- a high-active interrupt.

These runs show that gating and polarity decide the release. In the same runs, writes and a power-off strobe issued while stopped or waiting must leave no trace. The edge count from restart to the first enable pins the exact length of the stabilization wait after both reset and wake-up.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   typedef enum logic [1:0] {
      ST_WAIT = 2'd0,
      ST_RUN  = 2'd1,
      ST_STOP = 2'd2
   } clk_state_e;
endpackage

// File: rtl/clkctl_wake_det.sv
module clkctl_wake_det #(
   parameter int KEY_PAIRS = 4,
   parameter int IRQ_PINS  = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [2*KEY_PAIRS-1:0] key_n,
   input  logic [KEY_PAIRS-1:0]   key_en,
   input  logic [IRQ_PINS-1:0]    irq_pin,
   input  logic [IRQ_PINS-1:0]    irq_pol,
   output logic                   wake
);
   localparam int KEY_W = 2 * KEY_PAIRS;

   logic [KEY_W-1:0]     key_prev;
   logic [KEY_PAIRS-1:0] pair_fall;
   logic [IRQ_PINS-1:0]  irq_hit;

   // previous pin levels; idle (released) level is high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) key_prev <= '1;
      else        key_prev <= key_n;
   end

   genvar p;
   generate
      for (p = 0; p < KEY_PAIRS; p++) begin : g_pair
         assign pair_fall[p] = key_en[p] &
            (|(key_prev[2*p+1:2*p] & ~key_n[2*p+1:2*p]));
      end
   endgenerate

   genvar j;
   generate
      for (j = 0; j < IRQ_PINS; j++) begin : g_irq
         assign irq_hit[j] = irq_pol[j] ? irq_pin[j] : ~irq_pin[j];
      end
   endgenerate

   assign wake = (|pair_fall) | (|irq_hit);

   // a key event can only come from an enabled pair (R6)
   assert_key_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|pair_fall) |-> (|key_en));
endmodule

// File: rtl/clkctl_seq.sv
module clkctl_seq
   import clkctl_pkg::*;
#(
   parameter int WAIT_CYC = 256
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_off,
   input  logic       wake,
   output clk_state_e state,
   output logic       restart
);
   localparam int CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

   logic [CW-1:0] wcnt;

   initial begin
      assert (WAIT_CYC >= 2) else $error("WAIT_CYC must be at least 2");
   end

   assign restart = (state == ST_STOP) && wake;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_WAIT;
         wcnt  <= '0;
      end else begin
         unique case (state)
            ST_WAIT: begin
               if (wcnt == LAST) begin
                  state <= ST_RUN;
                  wcnt  <= '0;
               end else begin
                  wcnt <= wcnt + 1'b1;
               end
            end
            ST_RUN: begin
               if (pwr_off) state <= ST_STOP;
            end
            ST_STOP: begin
               if (wake) begin
                  state <= ST_WAIT;
                  wcnt  <= '0;
               end
            end
            default: begin
               state <= ST_WAIT;
               wcnt  <= '0;
            end
         endcase
      end
   end

   // stop ends only through the wait state (R8)
   assert_stop_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STOP && wake) |=> (state == ST_WAIT));
   // power-off during the wait is ignored (R10)
   assert_wait_no_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |=> (state != ST_STOP));
endmodule

// File: rtl/clkctl_div.sv
module clkctl_div #(
   parameter int INSTR_DIV = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic half_sel,
   output logic sys_en,
   output logic instr_en
);
   localparam int DW = $clog2(INSTR_DIV);
   localparam logic [DW-1:0] DLAST = DW'(INSTR_DIV - 1);

   logic          ph2;
   logic [DW-1:0] dcnt;

   initial begin
      assert (INSTR_DIV >= 2) else $error("INSTR_DIV must be at least 2");
   end

   assign sys_en   = run & (~half_sel | ph2);
   assign instr_en = sys_en & (dcnt == DLAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ph2 <= 1'b0;
      else if (!run) ph2 <= 1'b0;
      else          ph2 <= ~ph2;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dcnt <= '0;
      else if (!run)    dcnt <= '0;
      else if (sys_en)  dcnt <= (dcnt == DLAST) ? '0 : dcnt + 1'b1;
   end

   // instruction enable only rides on a system enable (R4)
   assert_instr_on_sys_R4: assert property (@(posedge clk) disable iff (!rst_n)
      instr_en |-> sys_en);
   // no instruction enable without a running clock (R5)
   assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!sys_en && !instr_en));
endmodule

// File: rtl/sysclk_wake_ctrl.sv
module sysclk_wake_ctrl
   import clkctl_pkg::*;
#(
   parameter int MODE_W    = 4,
   parameter int KEY_PAIRS = 4,
   parameter int IRQ_PINS  = 2,
   parameter int WAIT_CYC  = 256,
   parameter int INSTR_DIV = 3
) (
   input  logic                   clk_osc,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  logic [MODE_W-1:0]      reg_wdata,
   output logic [MODE_W-1:0]      reg_rdata,
   input  logic                   ken_wr,
   input  logic [KEY_PAIRS-1:0]   ken_wdata,
   input  logic                   pwr_off,
   input  logic [2*KEY_PAIRS-1:0] key_n,
   input  logic [IRQ_PINS-1:0]    irq_pin,
   input  logic [IRQ_PINS-1:0]    irq_pol,
   output logic                   sys_en,
   output logic                   instr_en,
   output logic                   halted,
   output logic                   warm_start
);
   localparam int SEL_BIT = MODE_W - 1;
   localparam logic [MODE_W-1:0] MODE_RST = {1'b1, {(MODE_W-1){1'b0}}};

   initial begin
      assert (MODE_W >= 2)    else $error("MODE_W must be at least 2");
      assert (KEY_PAIRS >= 1) else $error("KEY_PAIRS must be at least 1");
      assert (IRQ_PINS >= 1)  else $error("IRQ_PINS must be at least 1");
   end

   clk_state_e             state;
   logic                   restart;
   logic                   wake;
   logic                   run;
   logic [MODE_W-1:0]      mode_q;
   logic [KEY_PAIRS-1:0]   ken_q;
   logic                   warm_q;

   assign run        = (state == ST_RUN);
   assign halted     = (state == ST_STOP);
   assign reg_rdata  = mode_q;
   assign warm_start = warm_q;

   always_ff @(posedge clk_osc or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RST;
         ken_q  <= '0;
         warm_q <= 1'b0;
      end else begin
         if (restart)            mode_q <= MODE_RST;
         else if (run && reg_wr) mode_q <= reg_wdata;
         if (run && ken_wr)      ken_q  <= ken_wdata;
         if (restart)            warm_q <= 1'b1;
      end
   end

   clkctl_wake_det #(.KEY_PAIRS(KEY_PAIRS), .IRQ_PINS(IRQ_PINS)) u_wake (
      .clk     (clk_osc),
      .rst_n   (rst_n),
      .key_n   (key_n),
      .key_en  (ken_q),
      .irq_pin (irq_pin),
      .irq_pol (irq_pol),
      .wake    (wake)
   );

   clkctl_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
      .clk     (clk_osc),
      .rst_n   (rst_n),
      .pwr_off (pwr_off),
      .wake    (wake),
      .state   (state),
      .restart (restart)
   );

   clkctl_div #(.INSTR_DIV(INSTR_DIV)) u_div (
      .clk      (clk_osc),
      .rst_n    (rst_n),
      .run      (run),
      .half_sel (mode_q[SEL_BIT]),
      .sys_en   (sys_en),
      .instr_en (instr_en)
   );

   // half-rate enables never come back to back (R3)
   assert_half_rate_R3: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (sys_en && mode_q[SEL_BIT] && !reg_wr) |=> !sys_en);
   // power-off while running latches the stop state (R5)
   assert_pwroff_stops_R5: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (run && pwr_off) |=> (halted && !sys_en));
   // leaving stop restores half-rate mode and flags a warm start (R9)
   assert_wake_mode_R9: assert property (@(posedge clk_osc) disable iff (!rst_n)
      $fell(halted) |-> (reg_rdata == MODE_RST && warm_start));
   // no mode change during the stabilization wait (R10)
   assert_wait_mode_hold_R10: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (state == ST_WAIT) |=> $stable(mode_q));
endmodule

// File: tb/sysclk_wake_ctrl_tb_top.sv
module sysclk_wake_ctrl_tb_top;
   localparam int WAIT_CYC = 256;

   logic       clk_osc = 1'b0;
   logic       rst_n   = 1'b0;
   logic       reg_wr  = 1'b0;
   logic [3:0] reg_wdata = '0;
   logic [3:0] reg_rdata;
   logic       ken_wr  = 1'b0;
   logic [3:0] ken_wdata = '0;
   logic       pwr_off = 1'b0;
   logic [7:0] key_n   = 8'hFF;
   logic [1:0] irq_pin = 2'b11;
   logic [1:0] irq_pol = 2'b00;
   logic       sys_en, instr_en, halted, warm_start;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk_osc = ~clk_osc;

   sysclk_wake_ctrl #(.WAIT_CYC(WAIT_CYC)) dut_i (
      .clk_osc    (clk_osc),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .ken_wr     (ken_wr),
      .ken_wdata  (ken_wdata),
      .pwr_off    (pwr_off),
      .key_n      (key_n),
      .irq_pin    (irq_pin),
      .irq_pol    (irq_pol),
      .sys_en     (sys_en),
      .instr_en   (instr_en),
      .halted     (halted),
      .warm_start (warm_start)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr_mode(input logic [3:0] v);
      @(negedge clk_osc); reg_wr = 1'b1; reg_wdata = v;
      @(negedge clk_osc); reg_wr = 1'b0;
   endtask

   task automatic wr_ken(input logic [3:0] v);
      @(negedge clk_osc); ken_wr = 1'b1; ken_wdata = v;
      @(negedge clk_osc); ken_wr = 1'b0;
   endtask

   task automatic do_stop();
      @(negedge clk_osc); pwr_off = 1'b1;
      @(negedge clk_osc); pwr_off = 1'b0;
   endtask

   // edges until the first system enable, sampled on the falling edge
   task automatic edges_to_sys(output int n);
      n = 0;
      for (int k = 0; k < 2000; k++) begin
         @(posedge clk_osc); n++;
         @(negedge clk_osc);
         if (sys_en) break;
      end
   endtask

   task automatic count_window(input int len, output int ns, output int ni);
      ns = 0; ni = 0;
      for (int k = 0; k < len; k++) begin
         @(negedge clk_osc);
         if (sys_en)   ns++;
         if (instr_en) ni++;
      end
   endtask

   task automatic t_reset();
      int n;
      rst_n = 1'b0;
      repeat (3) @(negedge clk_osc);
      chk("R1 mode at reset", reg_rdata, 4'b1000);
      chk("R1 sys_en at reset", sys_en, 0);
      chk("R1 instr_en at reset", instr_en, 0);
      chk("R1 halted at reset", halted, 0);
      chk("R9 warm_start cleared by reset", warm_start, 0);
      rst_n = 1'b1;
      edges_to_sys(n);
      chk("R8 wait after reset", n, WAIT_CYC + 1);
   endtask

   task automatic t_reg_rw();
      wr_mode(4'b0111);
      @(negedge clk_osc); chk("R2 readback 0111", reg_rdata, 4'b0111);
      wr_mode(4'b1010);
      @(negedge clk_osc); chk("R2 readback 1010", reg_rdata, 4'b1010);
      wr_mode(4'b0101);
      @(negedge clk_osc); chk("R2 readback 0101", reg_rdata, 4'b0101);
   endtask

   task automatic t_rates();
      int ns, ni;
      wr_mode(4'b0110);
      count_window(12, ns, ni);
      chk("R3 fast-mode enables", ns, 12);
      chk("R4 instr enables fast", ni, 4);
      wr_mode(4'b1111);
      count_window(12, ns, ni);
      chk("R3 half-rate enables", ns, 6);
      chk("R4 instr enables half-rate", ni, 2);
   endtask

   task automatic t_stop_key();
      int ns, ni, n, pulses;
      wr_ken(4'b0001);
      wr_mode(4'b0000);
      do_stop();
      chk("R5 halted after power-off", halted, 1);
      count_window(20, ns, ni);
      chk("R5 no sys_en while halted", ns, 0);
      chk("R5 no instr_en while halted", ni, 0);
      // pair 1 disabled
      @(negedge clk_osc); key_n[2] = 1'b0;
      repeat (4) @(negedge clk_osc);
      chk("R6 disabled pair keeps halt", halted, 1);
      key_n[2] = 1'b1;
      // writes while stopped
      @(negedge clk_osc); ken_wr = 1'b1; ken_wdata = 4'b1111;
      reg_wr = 1'b1; reg_wdata = 4'b0011;
      @(negedge clk_osc); ken_wr = 1'b0; reg_wr = 1'b0;
      chk("R10 mode write ignored in stop", reg_rdata, 4'b0000);
      key_n[3] = 1'b0;
      repeat (4) @(negedge clk_osc);
      chk("R10 key-enable write ignored in stop", halted, 1);
      key_n[3] = 1'b1;
      // enabled pair 0
      @(negedge clk_osc); key_n[1] = 1'b0;
      @(posedge clk_osc);
      @(negedge clk_osc);
      chk("R6 enabled pair wakes", halted, 0);
      chk("R9 mode forced on wake", reg_rdata, 4'b1000);
      chk("R9 warm_start set", warm_start, 1);
      key_n[1] = 1'b1;
      pwr_off = 1'b1;
      n = 0;
      for (int k = 0; k < 2000; k++) begin
         @(posedge clk_osc); n++;
         @(negedge clk_osc);
         pwr_off = 1'b0;
         if (sys_en) break;
      end
      chk("R8 wait after wake", n, WAIT_CYC + 1);
      chk("R10 power-off ignored in wait", halted, 0);
      pulses = 1;
      chk("R4 no instr on first sys_en", instr_en, 0);
      for (int k = 0; k < 20; k++) begin
         @(negedge clk_osc);
         if (sys_en) pulses++;
         if (instr_en) break;
      end
      chk("R4 first instr on third sys_en", pulses, 3);
   endtask

   task automatic t_irq();
      int n;
      irq_pol = 2'b00; irq_pin = 2'b11;
      do_stop();
      chk("R5 halted before irq", halted, 1);
      @(negedge clk_osc); irq_pin[0] = 1'b0;
      @(posedge clk_osc);
      @(negedge clk_osc);
      chk("R7 low-active irq wakes", halted, 0);
      irq_pin[0] = 1'b1;
      edges_to_sys(n);
      irq_pin[1] = 1'b0; irq_pol = 2'b10;
      do_stop();
      repeat (4) @(negedge clk_osc);
      chk("R7 high-active irq idle low keeps halt", halted, 1);
      irq_pin[1] = 1'b1;
      @(posedge clk_osc);
      @(negedge clk_osc);
      chk("R7 high-active irq wakes", halted, 0);
      irq_pol = 2'b00; irq_pin = 2'b11;
      edges_to_sys(n);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_reg_rw();
      t_rates();
      t_stop_key();
      t_irq();
      t_reset();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule